// File: doc/BRIEF.md
# Byte-Lane SEC-DED Codec

This block guards a 16-bit word that is stored as two separate 8-bit lanes. Each lane carries its own 5-bit check field, so every lane is kept as a 13-bit codeword. The write path turns a data word and its two byte enables into one codeword per lane, plus a per-lane write strobe for the storage next to it. The read path takes the two stored codewords back, corrects any single flipped bit within a lane, and spots double flips.

Lane results are merged into two flags: one for an error that was corrected and one for an error that could not be corrected. Both flags can be set in the same read when one lane was repaired and the other lane is lost. A qualifier marks the cycles in which the flags mean something. That is a read with outputs enabled and no write in the same cycle. The flags are refreshed on every read cycle, in step with the data. A lane that is not enabled still shows its own status, but it does not feed the merged flags.

Top module: `lane_secded_codec`

## Requirements
- R1: Each lane codeword is 13 bits. Data bits d0..d7 sit at positions 3,5,6,7,9,10,11,12. Check bits sit at positions 1,2,4,8, and each gives even parity over every position 1..12 whose index has that bit set. Bit 0 makes the whole 13-bit codeword even parity. Lane 0 is at wr_cw[12:0] and lane 1 at wr_cw[25:13]. wr_cw is registered one cycle after a cycle with wr_req=1.
- R2: wr_lane_we equals wr_be one cycle after wr_req=1, and is 0 one cycle after wr_req=0.
- R3: A single flipped bit at any position of a lane is corrected. That lane's bit in lane_sec is set and the original byte is returned on rd_data.
- R4: Two flipped bits in a lane set that lane's bit in lane_ded, and never its bit in lane_sec.
- R5: If only bit 0 of a lane is wrong (zero syndrome, odd parity), this counts as a corrected single error, and the data byte is left unchanged.
- R6: A nonzero syndrome that points past position 12 while overall parity is odd is reported as uncorrectable.
- R7: err_single is 1 when at least one enabled lane had a corrected error. err_multi is 1 when at least one enabled lane is uncorrectable. Both are 1 when one enabled lane is corrected and the other is uncorrectable. Both are 0 for clean data.
- R8: A lane whose rd_be bit is 0 still reports in lane_sec/lane_ded, but it has no effect on err_single or err_multi.
- R9: flag_valid is 1 exactly one cycle after a cycle with rd_req=1, out_en=1 and wr_req=0. When flag_valid is 0, err_single, err_multi, lane_sec and lane_ded are all 0.
- R10: While rst is high, every output is 0 on the following clock edge.
- R11: Status does not stick. Each read's flags depend only on that read's codewords, so back-to-back reads can differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write cycle request |
| wr_be | input | 2 | Byte enables for the write, bit n = lane n |
| wr_data | input | 16 | Word to encode |
| wr_cw | output | 26 | Registered codewords, lane 1 above lane 0 |
| wr_lane_we | output | 2 | Registered per-lane write strobes |
| rd_req | input | 1 | Read cycle request |
| out_en | input | 1 | Read outputs enabled |
| rd_be | input | 2 | Byte enables for the read |
| rd_cw | input | 26 | Stored codewords being read |
| rd_data | output | 16 | Registered corrected word |
| lane_sec | output | 2 | Per-lane corrected-error status |
| lane_ded | output | 2 | Per-lane uncorrectable status |
| err_single | output | 1 | Some enabled lane was corrected |
| err_multi | output | 1 | Some enabled lane is uncorrectable |
| flag_valid | output | 1 | Flags are meaningful this cycle |

## Verification
The bench flips every one of the 13 positions in both lanes. A decoder with a wrong position map would return a damaged byte or miss the correction. The bench also flips every pair of positions in a lane. An extended-parity mistake would show there as a miscorrection reported as a single error. A flip of only the overall bit, and a triple flip whose syndrome points past the codeword, cover the two edges of the syndrome decode. A design that mishandled them would alter data or claim a repair. Reads with one lane disabled, writes that collide with reads, and reads with outputs off all target the flag gating. A gating bug would leak an ignored lane's error or raise the flags in a cycle where they are not valid.

// File: rtl/lane_ecc_pkg.sv
`timescale 1ns/1ps
package lane_ecc_pkg;

  typedef enum logic [1:0] {
    LANE_CLEAN = 2'd0,
    LANE_FIXED = 2'd1,
    LANE_BAD   = 2'd2
  } lane_stat_e;

  // number of Hamming check bits needed for a data width
  function automatic int hamming_bits(input int data_w);
    int p;
    p = 0;
    while ((1 << p) < data_w + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v & (v - 1)) == 0;
  endfunction

endpackage

// File: rtl/lane_ecc_enc.sv
`timescale 1ns/1ps
module lane_ecc_enc
  import lane_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_P  = hamming_bits(DATA_W),
  parameter int CW_W   = DATA_W + CHK_P + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);

  always_comb begin
    logic [CW_W-1:0] c;
    int j;
    c = '0;
    j = 0;
    // scatter data over the non power-of-two positions
    for (int pos = 1; pos < CW_W; pos++) begin
      if (!is_pow2(pos)) begin
        c[pos] = data_i[j];
        j++;
      end
    end
    // each check bit covers positions whose index has its bit set
    for (int k = 0; k < CHK_P; k++) begin
      logic acc;
      acc = 1'b0;
      for (int pos = 1; pos < CW_W; pos++) begin
        if (((pos >> k) & 1) == 1 && pos != (1 << k)) acc = acc ^ c[pos];
      end
      c[1 << k] = acc;
    end
    c[0] = ^c[CW_W-1:1];
    cw_o = c;
  end

endmodule

// File: rtl/lane_ecc_dec.sv
`timescale 1ns/1ps
module lane_ecc_dec
  import lane_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_P  = hamming_bits(DATA_W),
  parameter int CW_W   = DATA_W + CHK_P + 1
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output lane_stat_e        stat_o
);

  logic [CHK_P-1:0] syn;
  logic             par_odd;
  logic [CW_W-1:0]  fixed;

  always_comb begin
    syn = '0;
    for (int pos = 1; pos < CW_W; pos++) begin
      for (int k = 0; k < CHK_P; k++) begin
        if (((pos >> k) & 1) == 1) syn[k] = syn[k] ^ cw_i[pos];
      end
    end
    par_odd = ^cw_i;
  end

  always_comb begin
    fixed  = cw_i;
    stat_o = LANE_CLEAN;
    if (par_odd) begin
      if (syn == '0) begin
        stat_o = LANE_FIXED;            // only the overall bit is off
      end else if (int'(syn) < CW_W) begin
        stat_o = LANE_FIXED;
        for (int pos = 1; pos < CW_W; pos++) begin
          if (syn == CHK_P'(pos)) fixed[pos] = ~cw_i[pos];
        end
      end else begin
        stat_o = LANE_BAD;              // points outside the codeword
      end
    end else if (syn != '0) begin
      stat_o = LANE_BAD;
    end
  end

  always_comb begin
    int j;
    data_o = '0;
    j = 0;
    for (int pos = 1; pos < CW_W; pos++) begin
      if (!is_pow2(pos)) begin
        data_o[j] = fixed[pos];
        j++;
      end
    end
  end

endmodule

// File: rtl/lane_ecc_merge.sv
`timescale 1ns/1ps
module lane_ecc_merge #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] sec_i,
  input  logic [LANES-1:0] ded_i,
  input  logic [LANES-1:0] be_i,
  output logic             any_sec_o,
  output logic             any_ded_o
);

  assign any_sec_o = |(sec_i & be_i);
  assign any_ded_o = |(ded_i & be_i);

endmodule

// File: rtl/lane_secded_codec.sv
`timescale 1ns/1ps
module lane_secded_codec
  import lane_ecc_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int CHK_P  = hamming_bits(LANE_W),
  localparam int CW_W   = LANE_W + CHK_P + 1,
  localparam int WORD_W = LANES * LANE_W,
  localparam int BUS_W  = LANES * CW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [LANES-1:0]  wr_be,
  input  logic [WORD_W-1:0] wr_data,
  output logic [BUS_W-1:0]  wr_cw,
  output logic [LANES-1:0]  wr_lane_we,
  input  logic              rd_req,
  input  logic              out_en,
  input  logic [LANES-1:0]  rd_be,
  input  logic [BUS_W-1:0]  rd_cw,
  output logic [WORD_W-1:0] rd_data,
  output logic [LANES-1:0]  lane_sec,
  output logic [LANES-1:0]  lane_ded,
  output logic              err_single,
  output logic              err_multi,
  output logic              flag_valid
);

  logic [BUS_W-1:0]  enc_cw;
  logic [WORD_W-1:0] dec_data;
  logic [LANES-1:0]  dec_sec;
  logic [LANES-1:0]  dec_ded;
  logic              any_sec;
  logic              any_ded;
  logic              rd_active;
  logic              rd_visible;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_stat_e stat;

    lane_ecc_enc #(.DATA_W(LANE_W)) enc_i (
      .data_i (wr_data[g*LANE_W +: LANE_W]),
      .cw_o   (enc_cw[g*CW_W +: CW_W])
    );

    lane_ecc_dec #(.DATA_W(LANE_W)) dec_i (
      .cw_i   (rd_cw[g*CW_W +: CW_W]),
      .data_o (dec_data[g*LANE_W +: LANE_W]),
      .stat_o (stat)
    );

    assign dec_sec[g] = (stat == LANE_FIXED);
    assign dec_ded[g] = (stat == LANE_BAD);
  end

  lane_ecc_merge #(.LANES(LANES)) merge_i (
    .sec_i     (dec_sec),
    .ded_i     (dec_ded),
    .be_i      (rd_be),
    .any_sec_o (any_sec),
    .any_ded_o (any_ded)
  );

  assign rd_active  = rd_req & ~wr_req;
  assign rd_visible = rd_active & out_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cw      <= '0;
      wr_lane_we <= '0;
      rd_data    <= '0;
      lane_sec   <= '0;
      lane_ded   <= '0;
      err_single <= 1'b0;
      err_multi  <= 1'b0;
      flag_valid <= 1'b0;
    end else begin
      if (wr_req) wr_cw <= enc_cw;
      wr_lane_we <= wr_req ? wr_be : '0;
      if (rd_active) rd_data <= dec_data;
      lane_sec   <= rd_visible ? dec_sec : '0;
      lane_ded   <= rd_visible ? dec_ded : '0;
      err_single <= rd_visible & any_sec;
      err_multi  <= rd_visible & any_ded;
      flag_valid <= rd_visible;
    end
  end

endmodule

// File: rtl/lane_secded_codec_chk.sv
`timescale 1ns/1ps
module lane_secded_codec_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_req,
  input logic [LANES-1:0] wr_be,
  input logic [LANES-1:0] wr_lane_we,
  input logic             rd_req,
  input logic             out_en,
  input logic [LANES-1:0] rd_be,
  input logic [LANES-1:0] lane_sec,
  input logic [LANES-1:0] lane_ded,
  input logic             err_single,
  input logic             err_multi,
  input logic             flag_valid
);

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
    !flag_valid |-> (!err_single && !err_multi && lane_sec == '0 && lane_ded == '0)); // R9

  AST_WRITE_BLOCKS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !flag_valid); // R9

  AST_OUTPUT_OFF_BLOCKS_VALID: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !flag_valid); // R9

  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    (rd_req && out_en && !wr_req) |=> flag_valid); // R9

  AST_LANE_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (lane_sec & lane_ded) == '0); // R4

  AST_SINGLE_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    err_single |-> (lane_sec & $past(rd_be)) != '0); // R7

  AST_MULTI_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    err_multi |-> (lane_ded & $past(rd_be)) != '0); // R8

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_lane_we != '0) |-> $past(wr_req)); // R2

  AST_STROBE_WITHIN_BE: assert property (@(posedge clk) disable iff (rst)
    (wr_lane_we & ~$past(wr_be)) == '0); // R2

endmodule

bind lane_secded_codec lane_secded_codec_chk #(.LANES(LANES)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .wr_req     (wr_req),
  .wr_be      (wr_be),
  .wr_lane_we (wr_lane_we),
  .rd_req     (rd_req),
  .out_en     (out_en),
  .rd_be      (rd_be),
  .lane_sec   (lane_sec),
  .lane_ded   (lane_ded),
  .err_single (err_single),
  .err_multi  (err_multi),
  .flag_valid (flag_valid)
);

// File: tb/lane_secded_codec_tb_top.sv
`timescale 1ns/1ps
module lane_secded_codec_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_req = 1'b0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [25:0] wr_cw;
  logic [1:0]  wr_lane_we;
  logic        rd_req = 1'b0;
  logic        out_en = 1'b0;
  logic [1:0]  rd_be = '0;
  logic [25:0] rd_cw = '0;
  logic [15:0] rd_data;
  logic [1:0]  lane_sec;
  logic [1:0]  lane_ded;
  logic        err_single;
  logic        err_multi;
  logic        flag_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_secded_codec dut_i (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_be(wr_be), .wr_data(wr_data),
    .wr_cw(wr_cw), .wr_lane_we(wr_lane_we), .rd_req(rd_req), .out_en(out_en),
    .rd_be(rd_be), .rd_cw(rd_cw), .rd_data(rd_data), .lane_sec(lane_sec),
    .lane_ded(lane_ded), .err_single(err_single), .err_multi(err_multi),
    .flag_valid(flag_valid)
  );

  // codeword built from the R1 layout equations
  function automatic logic [12:0] ref_enc(input logic [7:0] d);
    logic [12:0] c;
    c = '0;
    c[3] = d[0]; c[5] = d[1]; c[6] = d[2]; c[7] = d[3];
    c[9] = d[4]; c[10] = d[5]; c[11] = d[6]; c[12] = d[7];
    c[1] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c[2] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[4] = d[1] ^ d[2] ^ d[3] ^ d[7];
    c[8] = d[4] ^ d[5] ^ d[6] ^ d[7];
    c[0] = ^c[12:1];
    return c;
  endfunction

  function automatic logic [25:0] ref_word(input logic [15:0] d);
    return {ref_enc(d[15:8]), ref_enc(d[7:0])};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wr_req = 1'b1; wr_be = be; wr_data = d; rd_req = 1'b0;
    @(negedge clk);
    wr_req = 1'b0; wr_be = '0;
  endtask

  task automatic do_read(input logic [25:0] cw, input logic [1:0] be, input logic oe);
    @(negedge clk);
    rd_req = 1'b1; out_en = oe; rd_be = be; rd_cw = cw;
    @(negedge clk);
    rd_req = 1'b0; out_en = 1'b0;
  endtask

  // data, lane0 flips, lane1 flips, rd_be, lanes with good data, exp single, exp multi
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {16'hA55A, 13'h0000, 13'h0000, 2'b11, 2'b11, 1'b0, 1'b0},
    {16'h1234, 13'h0020, 13'h0000, 2'b11, 2'b11, 1'b1, 1'b0},
    {16'hBEEF, 13'h0000, 13'h0001, 2'b11, 2'b11, 1'b1, 1'b0},
    {16'h00FF, 13'h0006, 13'h0000, 2'b11, 2'b10, 1'b0, 1'b1},
    {16'h7E81, 13'h0100, 13'h0003, 2'b11, 2'b01, 1'b1, 1'b1},
    {16'hC3C3, 13'h0800, 13'h0002, 2'b11, 2'b11, 1'b1, 1'b0},
    {16'h5A5A, 13'h0000, 13'h0180, 2'b01, 2'b01, 1'b0, 1'b0},
    {16'h0F0F, 13'h0010, 13'h0000, 2'b10, 2'b11, 1'b0, 1'b0},
    {16'h9669, 13'h1003, 13'h0000, 2'b11, 2'b10, 1'b0, 1'b1},
    {16'hFFFF, 13'h0000, 13'h0000, 2'b11, 2'b11, 1'b0, 1'b0}
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [25:0] base;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset outputs", {wr_cw, wr_lane_we, rd_data, lane_sec, lane_ded,
        err_single, err_multi, flag_valid}, '0);
    rst = 1'b0;

    // R1: known codewords
    do_write(16'hFF00, 2'b11);
    chk("R1 codeword 0x00/0xFF", {6'd0, wr_cw}, {6'd0, 13'h1EEE, 13'h0000});
    do_write(16'h0001, 2'b11);
    chk("R1 codeword 0x01", {19'd0, wr_cw[12:0]}, {19'd0, 13'h000F});

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [15:0] d;
      logic [12:0] m0, m1;
      logic [1:0]  be, good;
      logic        s, m;
      {d, m0, m1, be, good, s, m} = VEC[i];
      do_write(d, 2'b11);
      chk("R1 encode", {6'd0, wr_cw}, {6'd0, ref_word(d)});
      chk("R2 strobe", {30'd0, wr_lane_we}, 32'd3);
      do_read(wr_cw ^ {m1, m0}, be, 1'b1);
      chk("R7 flags (R3 R4 R5 R6 R8)", {29'd0, flag_valid, err_single, err_multi}, {29'd0, 1'b1, s, m});
      if (good[0]) chk("R3 lane0 data", {24'd0, rd_data[7:0]}, {24'd0, d[7:0]});
      if (good[1]) chk("R3 lane1 data", {24'd0, rd_data[15:8]}, {24'd0, d[15:8]});
    end

    // R8: disabled lane still reports
    do_read(ref_word(16'h5A5A) ^ {13'h0180, 13'h0}, 2'b01, 1'b1);
    chk("R8 disabled lane ded", {28'd0, lane_ded, err_multi, err_single}, {28'd0, 2'b10, 1'b0, 1'b0});
    do_read(ref_word(16'h0F0F) ^ {13'h0, 13'h0010}, 2'b10, 1'b1);
    chk("R8 disabled lane sec", {28'd0, lane_sec, err_single, err_multi}, {28'd0, 2'b01, 1'b0, 1'b0});

    // R5: overall bit only, data untouched
    do_read(ref_word(16'h3CA5) ^ 26'h1, 2'b11, 1'b1);
    chk("R5 overall bit", {12'd0, rd_data, lane_sec, err_single, err_multi},
        {12'd0, 16'h3CA5, 2'b01, 1'b1, 1'b0});

    // R6: syndrome past end
    do_read(ref_word(16'h3CA5) ^ {13'h1003, 13'h0}, 2'b11, 1'b1);
    chk("R6 out of range", {28'd0, lane_ded, err_single, err_multi}, {28'd0, 2'b10, 1'b0, 1'b1});

    // R2: partial byte enables and no write
    do_write(16'h1111, 2'b01);
    chk("R2 partial strobe", {30'd0, wr_lane_we}, 32'd1);
    @(negedge clk);
    chk("R2 strobe idle", {30'd0, wr_lane_we}, 32'd0);

    // R9: write alongside read, and read with outputs off
    @(negedge clk);
    wr_req = 1'b1; wr_be = 2'b11; wr_data = 16'h2222;
    rd_req = 1'b1; out_en = 1'b1; rd_be = 2'b11; rd_cw = ref_word(16'h0) ^ 26'h6;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0; out_en = 1'b0;
    chk("R9 write cycle", {29'd0, flag_valid, err_single, err_multi}, 32'd0);
    do_read(ref_word(16'h0) ^ 26'h6, 2'b11, 1'b0);
    chk("R9 outputs off", {27'd0, flag_valid, err_single, err_multi, lane_ded}, 32'd0);

    // R11: back-to-back reads
    @(negedge clk);
    rd_req = 1'b1; out_en = 1'b1; rd_be = 2'b11; rd_cw = ref_word(16'hABCD) ^ 26'h6;
    @(negedge clk);
    chk("R11 first read", {29'd0, flag_valid, err_single, err_multi}, {29'd0, 3'b101});
    rd_cw = ref_word(16'h1357);
    @(negedge clk);
    rd_req = 1'b0; out_en = 1'b0;
    chk("R11 second read", {13'd0, rd_data, flag_valid, err_single, err_multi},
        {13'd0, 16'h1357, 3'b100});

    // R3: every single position in both lanes
    base = ref_word(16'h3C96);
    for (int ln = 0; ln < 2; ln++) begin
      for (int b = 0; b < 13; b++) begin
        do_read(base ^ (26'd1 << (ln * 13 + b)), 2'b11, 1'b1);
        chk("R3 single flip", {12'd0, rd_data, lane_sec, err_single, err_multi},
            {12'd0, 16'h3C96, 2'(1 << ln), 1'b1, 1'b0});
      end
    end

    // R4: every pair in lane 1
    for (int a = 0; a < 13; a++) begin
      for (int b = a + 1; b < 13; b++) begin
        do_read(base ^ (26'd1 << (13 + a)) ^ (26'd1 << (13 + b)), 2'b11, 1'b1);
        chk("R4 double flip", {28'd0, lane_sec, lane_ded, err_single, err_multi},
            {28'd0, 2'b00, 2'b10, 1'b0, 1'b1});
      end
    end

    // R10: reset after activity
    @(negedge clk);
    rd_req = 1'b1; out_en = 1'b1; rd_be = 2'b11; rd_cw = base ^ 26'h6;
    rst = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; out_en = 1'b0;
    chk("R10 reset clears", {rd_data, lane_sec, lane_ded, err_single, err_multi, flag_valid, wr_lane_we}, '0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule